// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes divider settings for a frequency synthesizer from a slow three-wire bus: a bus clock, a data line and an enable strobe. The serial lines are brought into the system clock domain. A data bit is taken on every rising bus-clock edge, most significant bit first, into a shift register. The rising edge of enable ends the frame. The last bit sent (frame bit 0) is a control bit, and it steers the rest of the frame to one of two holding registers. One holds the reference ratio and the prescaler select. The other holds the swallow and main ratios.

The block also counts the bits in each frame. A frame whose length does not suit its control bit updates nothing and sets a framing-error flag. An accepted frame updates all the fields of its register in a single system cycle, and that same cycle carries a one-cycle load strobe for the divider logic downstream.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset every field output, both load strobes and the framing-error flag are 0.
- R2: Bits are taken on rising bus-clock edges while enable is low. The first bit sent ends up at the most significant frame position, and the last bit sent becomes frame bit 0, the control bit.
- R3: A frame of exactly 16 bits with control bit 1 is accepted into the reference register. Frame bits 14..1 become the reference ratio, with frame bit 1 as its LSB. Frame bit 15 becomes the prescaler select (1 = 64/65 division, 0 = 128/129).
- R4: A frame of exactly 19 bits with control bit 0 is accepted into the programmable register. Frame bits 7..1 become the swallow ratio, with frame bit 1 as its LSB. Frame bits 18..8 become the main ratio, with frame bit 8 as its LSB.
- R5: An accepted frame leaves the other register's fields unchanged. All fields of the register it loads change together, in the cycle its load strobe is high, and at no other time.
- R6: Any other frame length, including zero or more than 19 bits, changes no field, gives no load strobe and sets the framing-error flag. The flag stays set until the next accepted frame clears it.
- R7: Each accepted frame produces exactly one single-cycle pulse on its own load strobe. The two strobes are never high together.
- R8: Bus-clock edges taken while enable is high are ignored. This includes an edge that arrives in the same synchronized cycle as the enable rising edge.
- R9: The bit count restarts at every enable rising edge, so a frame after a rejected one is judged only on its own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial bus clock (asynchronous) |
| bus_data_i | input | 1 | Serial bus data (asynchronous) |
| bus_en_i | input | 1 | Serial bus enable / transfer strobe (asynchronous) |
| ref_ratio_o | output | 14 | Latched reference division ratio |
| presc_sel_o | output | 1 | Latched prescaler select, 1 = 64/65, 0 = 128/129 |
| swallow_o | output | 7 | Latched swallow ratio |
| main_ratio_o | output | 11 | Latched main ratio |
| ref_load_o | output | 1 | One-cycle strobe: reference register updated |
| prog_load_o | output | 1 | One-cycle strobe: programmable register updated |
| frame_err_o | output | 1 | Framing-error flag |

## Verification
A bit shift and the end-of-frame transfer can fall in the same synchronized cycle if the bus clock and enable rise together. The bench forces this by driving both lines high on the same system-clock falling edge. In one case the colliding edge would have carried the final control bit of a 16-bit frame; the frame must then be judged 15 bits long and rejected. In the other case the edge comes after a complete frame, and that frame must still be accepted with its fields intact.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Outcome of judging a frame at the enable rising edge
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_REF  = 2'd1,
    VERDICT_PROG = 2'd2,
    VERDICT_BAD  = 2'd3
  } verdict_e;

  // Positions of the three bus lines in the synchronizer vector
  localparam int LINE_CLK  = 0;
  localparam int LINE_DATA = 1;
  localparam int LINE_EN   = 2;
  localparam int LINE_CNT  = 3;

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      last_q  <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
      last_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
      assign rise_o[b] = stage_q[STAGES-1][b] & ~last_q[b];
    end
  endgenerate

endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
  parameter int FRAME_W = 19,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_i,
  input  logic               bit_i,
  input  logic               restart_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   count_o
);

  // Count stops one past the longest legal frame, so overlong frames stay illegal
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      count_q <= '0;
    end else begin
      if (shift_i) begin
        frame_q <= {frame_q[FRAME_W-2:0], bit_i};
      end
      if (restart_i) begin
        count_q <= '0;
      end else if (shift_i && (count_q != CNT_CAP)) begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign frame_o = frame_q;
  assign count_o = count_q;

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (count_q == '0)); // R9

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> (frame_q[0] == $past(bit_i))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(frame_q)); // R8

endmodule

// File: rtl/cfg_frame_judge.sv
module cfg_frame_judge
  import cfg_loader_pkg::*;
#(
  parameter int REF_LEN  = 16,
  parameter int PROG_LEN = 19,
  parameter int CNT_W    = 5
) (
  input  logic             strobe_i,
  input  logic             ctrl_bit_i,
  input  logic [CNT_W-1:0] count_i,
  output verdict_e         verdict_o
);

  localparam logic [CNT_W-1:0] REF_CNT  = CNT_W'(REF_LEN);
  localparam logic [CNT_W-1:0] PROG_CNT = CNT_W'(PROG_LEN);

  always_comb begin
    verdict_o = VERDICT_NONE;
    if (strobe_i) begin
      if (ctrl_bit_i && (count_i == REF_CNT)) begin
        verdict_o = VERDICT_REF;
      end else if (!ctrl_bit_i && (count_i == PROG_CNT)) begin
        verdict_o = VERDICT_PROG;
      end else begin
        verdict_o = VERDICT_BAD;
      end
    end
  end

endmodule

// File: rtl/cfg_holding_reg.sv
module cfg_holding_reg #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
    end else if (load_i) begin
      data_o <= data_i;
    end
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_RATIO_W = 14,
  parameter int SWALLOW_W   = 7,
  parameter int MAIN_W      = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_clk_i,
  input  logic                   bus_data_i,
  input  logic                   bus_en_i,
  output logic [REF_RATIO_W-1:0] ref_ratio_o,
  output logic                   presc_sel_o,
  output logic [SWALLOW_W-1:0]   swallow_o,
  output logic [MAIN_W-1:0]      main_ratio_o,
  output logic                   ref_load_o,
  output logic                   prog_load_o,
  output logic                   frame_err_o
);

  localparam int REF_LEN    = REF_RATIO_W + 2;
  localparam int PROG_LEN   = SWALLOW_W + MAIN_W + 1;
  localparam int FRAME_W    = (PROG_LEN > REF_LEN) ? PROG_LEN : REF_LEN;
  localparam int CNT_W      = $clog2(FRAME_W + 2);
  localparam int REF_PAY_W  = REF_LEN - 1;
  localparam int PROG_PAY_W = PROG_LEN - 1;

  logic [LINE_CNT-1:0] line_level;
  logic [LINE_CNT-1:0] line_rise;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    bit_count;
  logic [REF_PAY_W-1:0]  ref_word;
  logic [PROG_PAY_W-1:0] prog_word;
  verdict_e            verdict;
  logic                en_rise;
  logic                shift_ok;
  logic                take_ref;
  logic                take_prog;
  logic                take_bad;
  logic                ref_load_q;
  logic                prog_load_q;
  logic                err_q;

  cfg_bus_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINE_CNT)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({bus_en_i, bus_data_i, bus_clk_i}),
    .level_o (line_level),
    .rise_o  (line_rise)
  );

  assign en_rise  = line_rise[LINE_EN];
  // No shifting while enable is high, including the cycle it rises
  assign shift_ok = line_rise[LINE_CLK] & ~line_level[LINE_EN];

  cfg_frame_shifter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_i   (shift_ok),
    .bit_i     (line_level[LINE_DATA]),
    .restart_i (en_rise),
    .frame_o   (frame),
    .count_o   (bit_count)
  );

  cfg_frame_judge #(
    .REF_LEN  (REF_LEN),
    .PROG_LEN (PROG_LEN),
    .CNT_W    (CNT_W)
  ) u_judge (
    .strobe_i   (en_rise),
    .ctrl_bit_i (frame[0]),
    .count_i    (bit_count),
    .verdict_o  (verdict)
  );

  assign take_ref  = (verdict == VERDICT_REF);
  assign take_prog = (verdict == VERDICT_PROG);
  assign take_bad  = (verdict == VERDICT_BAD);

  cfg_holding_reg #(
    .WIDTH (REF_PAY_W)
  ) u_ref_reg (
    .clk    (clk),
    .rst    (rst),
    .load_i (take_ref),
    .data_i (frame[REF_LEN-1:1]),
    .data_o (ref_word)
  );

  cfg_holding_reg #(
    .WIDTH (PROG_PAY_W)
  ) u_prog_reg (
    .clk    (clk),
    .rst    (rst),
    .load_i (take_prog),
    .data_i (frame[PROG_LEN-1:1]),
    .data_o (prog_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_load_q  <= 1'b0;
      prog_load_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      ref_load_q  <= take_ref;
      prog_load_q <= take_prog;
      if (take_bad) begin
        err_q <= 1'b1;
      end else if (take_ref || take_prog) begin
        err_q <= 1'b0;
      end
    end
  end

  assign ref_ratio_o  = ref_word[REF_RATIO_W-1:0];
  assign presc_sel_o  = ref_word[REF_PAY_W-1];
  assign swallow_o    = prog_word[SWALLOW_W-1:0];
  assign main_ratio_o = prog_word[PROG_PAY_W-1:SWALLOW_W];
  assign ref_load_o   = ref_load_q;
  assign prog_load_o  = prog_load_q;
  assign frame_err_o  = err_q;

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_load_o, prog_load_o})); // R7

  AST_REF_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    ref_load_o |=> !ref_load_o); // R7

  AST_PROG_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    prog_load_o |=> !prog_load_o); // R7

  AST_REF_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    !ref_load_o |-> $stable({presc_sel_o, ref_ratio_o})); // R5

  AST_PROG_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    !prog_load_o |-> $stable({main_ratio_o, swallow_o})); // R5

  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err_o) |-> (!ref_load_o && !prog_load_o)); // R6

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_err_o) |-> (ref_load_o || prog_load_o)); // R6

endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;

  localparam int HALF_BIT = 4;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clk = 1'b0;
  logic        bus_data = 1'b0;
  logic        bus_en = 1'b0;
  logic [13:0] ref_ratio;
  logic        presc_sel;
  logic [6:0]  swallow;
  logic [10:0] main_ratio;
  logic        ref_load;
  logic        prog_load;
  logic        frame_err;

  int checks = 0;
  int fails = 0;
  int ref_pulses = 0;
  int prog_pulses = 0;

  logic [13:0] exp_ref = '0;
  logic        exp_psc = 1'b0;
  logic [6:0]  exp_sw = '0;
  logic [10:0] exp_main = '0;
  logic        exp_err = 1'b0;
  int          exp_refp = 0;
  int          exp_progp = 0;

  always #4 clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk          (clk),
    .rst          (rst),
    .bus_clk_i    (bus_clk),
    .bus_data_i   (bus_data),
    .bus_en_i     (bus_en),
    .ref_ratio_o  (ref_ratio),
    .presc_sel_o  (presc_sel),
    .swallow_o    (swallow),
    .main_ratio_o (main_ratio),
    .ref_load_o   (ref_load),
    .prog_load_o  (prog_load),
    .frame_err_o  (frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ref_load)  ref_pulses++;
      if (prog_load) prog_pulses++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(ref_ratio == exp_ref, {req, " ref_ratio"}, ref_ratio, exp_ref);
    chk(presc_sel == exp_psc, {req, " presc_sel"}, presc_sel, exp_psc);
    chk(swallow == exp_sw, {req, " swallow"}, swallow, exp_sw);
    chk(main_ratio == exp_main, {req, " main_ratio"}, main_ratio, exp_main);
    chk(frame_err == exp_err, {req, " frame_err"}, frame_err, exp_err);
    chk(ref_pulses == exp_refp, {req, " ref pulse count"}, ref_pulses, exp_refp);
    chk(prog_pulses == exp_progp, {req, " prog pulse count"}, prog_pulses, exp_progp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b);
    bus_data = b;
    bus_clk  = 1'b0;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b1;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b0;
  endtask

  // First bit sent is bits[len-1]
  task automatic send_bits(input logic [31:0] bits, input int len);
    for (int i = len - 1; i >= 0; i--) bus_bit(bits[i]);
  endtask

  task automatic strobe();
    bus_en = 1'b1;
    wait_cyc(HALF_BIT);
    bus_en = 1'b0;
    wait_cyc(HALF_BIT + 4);
  endtask

  initial begin
    wait_cyc(WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual=%0d cycles expected=<%0d", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    // R1: reset state
    check_all("R1 reset");

    // R3 R2 R5 R7: sweep of reference frames
    for (int i = 0; i < 24; i++) begin
      logic [13:0] r;
      logic        p;
      r = 14'((i * 2731 + 4) & 16'h3fff);
      p = i[0];
      send_bits({16'd0, p, r, 1'b1}, 16);
      strobe();
      exp_ref = r; exp_psc = p; exp_refp++;
      check_all("R3 reference frame");
    end

    // R4 R2 R5 R7: sweep of programmable frames
    for (int i = 0; i < 24; i++) begin
      logic [6:0]  s;
      logic [10:0] m;
      s = 7'((i * 37 + 3) & 8'h7f);
      m = 11'((i * 211 + 5) & 12'h7ff);
      send_bits({13'd0, m, s, 1'b0}, 19);
      strobe();
      exp_sw = s; exp_main = m; exp_progp++;
      check_all("R4 programmable frame");
    end

    // R6: every wrong length for both control bit values
    for (int len = 0; len <= 22; len++) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] pat;
        if ((c == 1 && len == 16) || (c == 0 && len == 19)) continue;
        pat = {31'(len * 977 + 13), c[0]};
        send_bits(pat, len);
        strobe();
        exp_err = 1'b1;
        check_all("R6 bad length");
      end
    end

    // R9 R6: good frame right after a bad one is accepted and clears the flag
    send_bits(32'h15, 5);
    strobe();
    check_all("R9 short frame");
    send_bits({16'd0, 1'b1, 14'h2a5c, 1'b1}, 16);
    strobe();
    exp_ref = 14'h2a5c; exp_psc = 1'b1; exp_refp++; exp_err = 1'b0;
    check_all("R9 recount after error");

    // R8: bus clocks while enable is high are ignored
    send_bits({13'd0, 11'h4f1, 7'h2b, 1'b0}, 19);
    bus_en = 1'b1;
    wait_cyc(HALF_BIT);
    for (int k = 0; k < 6; k++) bus_bit(k[0]);
    bus_en = 1'b0;
    wait_cyc(HALF_BIT + 4);
    exp_sw = 7'h2b; exp_main = 11'h4f1; exp_progp++;
    check_all("R8 enable-high frame accepted");
    send_bits({16'd0, 1'b0, 14'h0137, 1'b1}, 16);
    strobe();
    exp_ref = 14'h0137; exp_psc = 1'b0; exp_refp++;
    check_all("R8 edges under enable not counted");

    // R8: bus clock edge coincident with enable rise carries the control bit
    send_bits({17'd0, 1'b1, 14'h1111}, 15);
    bus_data = 1'b1;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b1;
    bus_en  = 1'b1;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b0;
    bus_en  = 1'b0;
    wait_cyc(HALF_BIT + 4);
    exp_err = 1'b1;
    check_all("R8 coincident edge dropped");

    // R8: coincident extra edge after a complete frame does not spoil it
    send_bits({16'd0, 1'b1, 14'h3ffe, 1'b1}, 16);
    bus_data = 1'b0;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b1;
    bus_en  = 1'b1;
    wait_cyc(HALF_BIT);
    bus_clk = 1'b0;
    bus_en  = 1'b0;
    wait_cyc(HALF_BIT + 4);
    exp_ref = 14'h3ffe; exp_psc = 1'b1; exp_refp++; exp_err = 1'b0;
    check_all("R8 coincident edge after full frame");

    // R7: idle time produces no extra pulses
    wait_cyc(50);
    check_all("R7 idle quiet");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule